// File: doc/BRIEF.md
# Keyed DRAM Power-State Controller

This block is the power-state corner of a DRAM controller. It owns one register whose bit 0 shows that the memory is parked in self-refresh, keeping its contents. It drives a downstream command port that carries self-refresh-entry, self-refresh-exit and refresh commands. Software changes the power state by writing that register. A write is honoured only when the upper half-word of the written value carries a fixed unlock key. Any other write is dropped without effect.

A keyed write with bit 0 set parks the memory. It issues a single self-refresh-entry command, and the status bit rises once the command has been accepted. A keyed write with an all-zero lower half-word brings a parked memory back with a fixed three-command restore sequence: entry, exit, refresh. The status bit clears when the refresh is accepted. A busy output covers every command in flight. While busy is high the block ignores writes, and the key field of the read value reads as zero.

Top module: `dram_pwr_keyctl`

## Requirements
- R1: After reset, rd_data[15:0] is 0, busy is 0 and cmd_valid is 0; while idle, rd_data[31:16] reads the key 0x1651.
- R2: A write whose wr_data[31:16] differs from 0x1651 changes no part of rd_data and issues no command.
- R3: A keyed write with wr_data[0]=1 while rd_data[0]=0 issues exactly one command, code 0x12, and rd_data[0] becomes 1 after that command is accepted.
- R4: A keyed write with wr_data[15:0]=0 while rd_data[0]=1 issues exactly the codes 0x12, 0x17, 0x13 in that order, and rd_data[0] becomes 0 after the 0x13 is accepted.
- R5: A keyed write issues no command and leaves rd_data[0] unchanged in these cases: wr_data[0]=1 while rd_data[0]=1; wr_data[15:0]=0 while rd_data[0]=0; wr_data[0]=0 with a nonzero wr_data[15:1] while rd_data[0]=1.
- R6: rd_data[15:1] reads back wr_data[15:1] of the most recent accepted keyed write.
- R7: A presented command keeps cmd_valid high and cmd_code unchanged until cmd_ready is seen. The next command is presented only after that acceptance.
- R8: busy rises in the cycle after a write that starts commands. It stays high until the cycle after the last command of that request is accepted.
- R9: While busy is high, keyed writes are ignored, including one in the same cycle as the final acceptance, and rd_data[31:16] reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value: key in 31:16, control in 15:0 |
| rd_data | output | 32 | Register read value |
| cmd_valid | output | 1 | Command present on cmd_code |
| cmd_ready | input | 1 | Downstream accepts the presented command |
| cmd_code | output | 8 | Command code (0x12 entry, 0x17 exit, 0x13 refresh) |
| busy | output | 1 | Command request in progress |

## Verification
A register write and the acceptance of the last command of a request can land on the same clock edge. At that edge the sequencer is still marked busy, although busy falls one cycle later. The bench provokes this case from its command stub. In the very negedge where it raises ready for the refresh command, it also drives a keyed park write. It then judges the result after the sequence ends: no further command may appear, and the status bit must read 0. That shows the write was dropped and was not queued behind the restore.

// File: rtl/dpk_pkg.sv
package dpk_pkg;

    // Command codes carried on the downstream port
    localparam logic [7:0] CODE_SR_ENTER = 8'h12;
    localparam logic [7:0] CODE_SR_EXIT  = 8'h17;
    localparam logic [7:0] CODE_REFRESH  = 8'h13;

    // Unlock key expected in the upper half-word
    localparam logic [15:0] UNLOCK_KEY = 16'h1651;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_ENTER   = 2'd1,
        SEQ_EXIT    = 2'd2,
        SEQ_REFRESH = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       restore;   // 1: full restore sequence, 0: park only
    } seq_regs_t;

endpackage

// File: rtl/dpk_key_gate.sv
module dpk_key_gate #(
    parameter int          DATA_W  = 32,
    parameter int          KEY_W   = 16,
    parameter logic [15:0] KEY_VAL = dpk_pkg::UNLOCK_KEY
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              status,
    output logic              accept,
    output logic              start_enter,
    output logic              start_restore
);
    localparam int LOW_W = DATA_W - KEY_W;

    logic key_ok;
    logic low_zero;

    always_comb begin
        key_ok        = (wr_data[DATA_W-1:LOW_W] == KEY_VAL[KEY_W-1:0]);
        low_zero      = (wr_data[LOW_W-1:0] == '0);
        accept        = wr_en && key_ok && !busy;
        start_enter   = accept && !status && wr_data[0];
        start_restore = accept && status && low_zero;
    end

endmodule

// File: rtl/dpk_cmd_seq.sv
module dpk_cmd_seq #(
    parameter int             CMD_W        = 8,
    parameter logic [CMD_W-1:0] ENTER_CODE   = dpk_pkg::CODE_SR_ENTER,
    parameter logic [CMD_W-1:0] EXIT_CODE    = dpk_pkg::CODE_SR_EXIT,
    parameter logic [CMD_W-1:0] REFRESH_CODE = dpk_pkg::CODE_REFRESH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_enter,
    input  logic             start_restore,
    input  logic             cmd_ready,
    output logic             cmd_valid,
    output logic [CMD_W-1:0] cmd_code,
    output logic             busy,
    output logic             done_enter,
    output logic             done_restore
);
    import dpk_pkg::*;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d        = seq_q;
        done_enter   = 1'b0;
        done_restore = 1'b0;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (start_restore) begin
                    seq_d.state   = SEQ_ENTER;
                    seq_d.restore = 1'b1;
                end else if (start_enter) begin
                    seq_d.state   = SEQ_ENTER;
                    seq_d.restore = 1'b0;
                end
            end
            SEQ_ENTER: begin
                if (cmd_ready) begin
                    if (seq_q.restore) begin
                        seq_d.state = SEQ_EXIT;
                    end else begin
                        seq_d.state = SEQ_IDLE;
                        done_enter  = 1'b1;
                    end
                end
            end
            SEQ_EXIT: begin
                if (cmd_ready) begin
                    seq_d.state = SEQ_REFRESH;
                end
            end
            SEQ_REFRESH: begin
                if (cmd_ready) begin
                    seq_d.state   = SEQ_IDLE;
                    seq_d.restore = 1'b0;
                    done_restore  = 1'b1;
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_IDLE, restore: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        cmd_valid = (seq_q.state != SEQ_IDLE);
        busy      = cmd_valid;
        unique case (seq_q.state)
            SEQ_ENTER:   cmd_code = ENTER_CODE;
            SEQ_EXIT:    cmd_code = EXIT_CODE;
            SEQ_REFRESH: cmd_code = REFRESH_CODE;
            default:     cmd_code = '0;
        endcase
    end

endmodule

// File: rtl/dpk_state_reg.sv
module dpk_state_reg #(
    parameter int          DATA_W  = 32,
    parameter int          KEY_W   = 16,
    parameter logic [15:0] KEY_VAL = dpk_pkg::UNLOCK_KEY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              done_enter,
    input  logic              done_restore,
    input  logic              busy,
    output logic              status,
    output logic [DATA_W-1:0] rd_data
);
    localparam int LOW_W  = DATA_W - KEY_W;
    localparam int SCR_W  = LOW_W - 1;

    typedef struct packed {
        logic [SCR_W-1:0] scratch;
        logic             parked;
    } pwr_regs_t;

    pwr_regs_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (accept) begin
            reg_d.scratch = wr_data[LOW_W-1:1];
        end
        if (done_enter) begin
            reg_d.parked = 1'b1;
        end else if (done_restore) begin
            reg_d.parked = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    always_comb begin
        status  = reg_q.parked;
        rd_data = {(busy ? {KEY_W{1'b0}} : KEY_VAL[KEY_W-1:0]), reg_q.scratch, reg_q.parked};
    end

endmodule

// File: rtl/dram_pwr_keyctl.sv
module dram_pwr_keyctl #(
    parameter int          DATA_W  = 32,
    parameter int          KEY_W   = 16,
    parameter int          CMD_W   = 8,
    parameter logic [15:0] KEY_VAL = dpk_pkg::UNLOCK_KEY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [CMD_W-1:0]  cmd_code,
    output logic              busy
);
    logic accept;
    logic start_enter;
    logic start_restore;
    logic done_enter;
    logic done_restore;
    logic status;

    dpk_key_gate #(
        .DATA_W (DATA_W),
        .KEY_W  (KEY_W),
        .KEY_VAL(KEY_VAL)
    ) gate_i (
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .busy         (busy),
        .status       (status),
        .accept       (accept),
        .start_enter  (start_enter),
        .start_restore(start_restore)
    );

    dpk_cmd_seq #(
        .CMD_W       (CMD_W),
        .ENTER_CODE  (CMD_W'(dpk_pkg::CODE_SR_ENTER)),
        .EXIT_CODE   (CMD_W'(dpk_pkg::CODE_SR_EXIT)),
        .REFRESH_CODE(CMD_W'(dpk_pkg::CODE_REFRESH))
    ) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_enter  (start_enter),
        .start_restore(start_restore),
        .cmd_ready    (cmd_ready),
        .cmd_valid    (cmd_valid),
        .cmd_code     (cmd_code),
        .busy         (busy),
        .done_enter   (done_enter),
        .done_restore (done_restore)
    );

    dpk_state_reg #(
        .DATA_W (DATA_W),
        .KEY_W  (KEY_W),
        .KEY_VAL(KEY_VAL)
    ) state_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .wr_data     (wr_data),
        .done_enter  (done_enter),
        .done_restore(done_restore),
        .busy        (busy),
        .status      (status),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/dram_pwr_keyctl_chk.sv
module dram_pwr_keyctl_chk #(
    parameter int          DATA_W  = 32,
    parameter int          KEY_W   = 16,
    parameter int          CMD_W   = 8,
    parameter logic [15:0] KEY_VAL = dpk_pkg::UNLOCK_KEY
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [CMD_W-1:0]  cmd_code,
    input logic              busy
);
    localparam int LOW_W = DATA_W - KEY_W;

    // R7
    hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code)));

    // R4
    exit_then_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_code == CMD_W'(dpk_pkg::CODE_SR_EXIT))
        |=> (cmd_valid && cmd_code == CMD_W'(dpk_pkg::CODE_REFRESH)));

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cmd_valid && cmd_ready));

    // R9
    key_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rd_data[DATA_W-1:LOW_W] == '0));

    // R2
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && wr_data[DATA_W-1:LOW_W] != KEY_VAL[KEY_W-1:0])
        |=> $stable(rd_data[LOW_W-1:0]));

    // R3
    park_after_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[0]) |-> $past(cmd_valid && cmd_ready &&
                                    cmd_code == CMD_W'(dpk_pkg::CODE_SR_ENTER)));

    // R4
    wake_after_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[0]) |-> $past(cmd_valid && cmd_ready &&
                                    cmd_code == CMD_W'(dpk_pkg::CODE_REFRESH)));

endmodule

bind dram_pwr_keyctl dram_pwr_keyctl_chk #(
    .DATA_W (DATA_W),
    .KEY_W  (KEY_W),
    .CMD_W  (CMD_W),
    .KEY_VAL(KEY_VAL)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_code (cmd_code),
    .busy     (busy)
);

// File: tb/dram_pwr_keyctl_tb_top.sv
`timescale 1ns/1ps
module dram_pwr_keyctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [7:0]  cmd_code;
    logic        busy;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;

    // command stub state
    int unsigned ready_delay = 0;
    int unsigned wait_cnt    = 0;
    int unsigned n_cmd       = 0;
    logic [7:0]  cmd_log [0:7];
    logic        inject_on_refresh = 1'b0;
    logic        inject_drop       = 1'b0;

    always #2.5 clk = ~clk;

    dram_pwr_keyctl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready),
        .cmd_code (cmd_code),
        .busy     (busy)
    );

    // Downstream stub: acknowledges each command after ready_delay cycles
    always @(negedge clk) begin
        if (inject_drop) begin
            wr_en       = 1'b0;
            inject_drop = 1'b0;
        end
        if (cmd_ready) begin
            cmd_ready = 1'b0;
            wait_cnt  = 0;
        end else if (cmd_valid) begin
            if (wait_cnt >= ready_delay) begin
                cmd_ready = 1'b1;
                if (n_cmd < 8) cmd_log[n_cmd] = cmd_code;
                n_cmd = n_cmd + 1;
                if (inject_on_refresh && cmd_code == 8'h13) begin
                    wr_en             = 1'b1;
                    wr_data           = 32'h1651_0001;
                    inject_on_refresh = 1'b0;
                    inject_drop       = 1'b1;
                end
            end else begin
                wait_cnt = wait_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic [3:0]  exp_n;
        logic [23:0] exp_seq;   // first command in bits 23:16
        logic [3:0]  delay;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        // R2 no key
        '{32'h0000_0001, 32'h1651_0000, 4'd0, 24'h000000, 4'd0, 4'd2},
        // R3 park
        '{32'h1651_0001, 32'h1651_0001, 4'd1, 24'h120000, 4'd0, 4'd3},
        // R5 park while parked
        '{32'h1651_0001, 32'h1651_0001, 4'd0, 24'h000000, 4'd0, 4'd5},
        // R2 near-miss key
        '{32'h1650_0000, 32'h1651_0001, 4'd0, 24'h000000, 4'd0, 4'd2},
        // R4 restore
        '{32'h1651_0000, 32'h1651_0000, 4'd3, 24'h121713, 4'd0, 4'd4},
        // R5 restore while awake
        '{32'h1651_0000, 32'h1651_0000, 4'd0, 24'h000000, 4'd1, 4'd5},
        // R6 scratch bits, no command
        '{32'h1651_00A4, 32'h1651_00A4, 4'd0, 24'h000000, 4'd0, 4'd6},
        // R3 park with scratch bits
        '{32'h1651_00A5, 32'h1651_00A5, 4'd1, 24'h120000, 4'd2, 4'd3},
        // R5 nonzero lower half while parked, R6 scratch updates
        '{32'h1651_0008, 32'h1651_0009, 4'd0, 24'h000000, 4'd0, 4'd5},
        // R4 restore with slow ready
        '{32'h1651_0000, 32'h1651_0000, 4'd3, 24'h121713, 4'd3, 4'd4}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_fail = n_fail + 1;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rd_data", rd_data, 32'h1651_0000);
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 cmd_valid", {31'd0, cmd_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 rd_data after release", rd_data, 32'h1651_0000);

        // Vector walk
        for (int v = 0; v < NVEC; v++) begin
            tag         = $sformatf("R%0d vec%0d", VECS[v].req, v);
            ready_delay = VECS[v].delay;
            n_cmd       = 0;
            do_write(VECS[v].wdata);
            wait_idle();
            repeat (3) @(negedge clk);
            check({tag, " rd_data"}, rd_data, VECS[v].exp_rd);
            check({tag, " cmd count"}, n_cmd, {28'd0, VECS[v].exp_n});
            for (int k = 0; k < 3; k++) begin
                if (k < VECS[v].exp_n)
                    check({tag, " R7 cmd order"}, {24'd0, cmd_log[k]},
                          {24'd0, VECS[v].exp_seq[23-8*k -: 8]});
            end
        end

        // R8 / R9 / R7: park with slow ready, keyed write while busy
        ready_delay = 5;
        n_cmd       = 0;
        do_write(32'h1651_0001);
        check("R8 busy after start", {31'd0, busy}, 32'd1);
        check("R9 key field hidden", {16'd0, rd_data[31:16]}, 32'd0);
        check("R7 entry presented", {23'd0, cmd_valid, cmd_code}, {23'd0, 1'b1, 8'h12});
        do_write(32'h1651_00FE);
        check("R7 entry held", {23'd0, cmd_valid, cmd_code}, {23'd0, 1'b1, 8'h12});
        wait_idle();
        repeat (2) @(negedge clk);
        check("R8 busy low after done", {31'd0, busy}, 32'd0);
        check("R9 write during busy ignored", rd_data, 32'h1651_0001);
        check("R9 single command", n_cmd, 32'd1);

        // R9 write landing in the same cycle as refresh acceptance
        ready_delay       = 1;
        n_cmd             = 0;
        inject_on_refresh = 1'b1;
        do_write(32'h1651_0000);
        wait_idle();
        repeat (6) @(negedge clk);
        check("R9 same-cycle write dropped rd", rd_data, 32'h1651_0000);
        check("R9 same-cycle write no command", n_cmd, 32'd3);
        check("R4 last command refresh", {24'd0, cmd_log[2]}, 32'h13);

        // R2 unkeyed write while idle leaves everything
        n_cmd = 0;
        do_write(32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        check("R2 all-ones unkeyed", rd_data, 32'h1651_0000);
        check("R2 no command", n_cmd, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule